// File: doc/BRIEF.md
# Tick-Rate Selector with Source-Gated Prescaler

This block derives a slower tick stream from one of four incoming tick streams, all inside one system clock domain. Each incoming stream is a train of single-cycle enable pulses that represents a parent clock. A select field picks one of the four. Only the highest-numbered stream is routed through a 5-bit prescaler before it reaches a shared 2-bit output divider. The other three streams go straight to the output divider. The result leaves as a registered, one-cycle-wide tick.

All settings live in one 32-bit configuration word. Each write carries a per-bit mask, so a single field can be changed without disturbing the rest; this is a read-modify-write that the block performs itself. The word can be read back at all times. Whenever a write changes the source select, the prescale code or the output-divide code, both counters are cleared. The next output tick then comes only after a complete new period. A write that touches only the free bits leaves the counters running.

A two-state path machine tracks which route is active:
- `PATH_DIRECT`: the prescaler is bypassed. This is the reset state.
- `PATH_PRESCALED`: the prescaler is in series.

The transition DIRECT→PRESCALED is taken when a committed field change sets the select to 3. The transition PRESCALED→DIRECT is taken when a committed field change sets it to any other value. Every other cycle holds the current state.

Top module: `tick_rate_sel`

## Requirements
- R1: After reset, the configuration word reads 0 (source 0, both ratios 1) and `tick_out` is low.
- R2: Configuration bits 17:16 select the source tick stream: value n picks `src_tick[n]`, for n from 0 to 3.
- R3: Bits 5:4 hold the output-divide code c. One output tick is produced for every c+1 ticks reaching the output divider, so no two output ticks are adjacent when c is nonzero.
- R4: Bits 12:8 hold the prescale code p, giving a ratio of p+1 (1 to 32). When the select is 0, 1 or 2 the prescaler is bypassed, and the output rate does not depend on p.
- R5: With source 3 selected, N source ticks yield floor(N / ((p+1)(c+1))) output ticks. The prescaler divides first and the output divider divides second.
- R6: A write with `wr_en` high changes exactly the bits whose `wr_mask` bit is 1, loading them from `wr_data`. Without a write, the word holds its value. `rd_data` shows the stored word from the cycle after the write.
- R7: Bits outside the three fields read back their last written value and have no effect. A write that changes only those bits does not disturb the counters.
- R8: A write that changes any of the three fields clears both counters. The selected tick in that write cycle is discarded, and `tick_out` is low in the following cycle.
- R9: `tick_out` is registered. It rises one clock after the selected source tick that completes a period, and it is high for one cycle per completion. With both ratios 1, every selected source tick appears on `tick_out` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_tick | input | 4 | One single-cycle enable pulse stream per source |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 32 | Write data for the configuration word |
| wr_mask | input | 32 | Per-bit write enable; 1 means the bit is replaced |
| rd_data | output | 32 | Current configuration word |
| tick_out | output | 1 | Divided output tick, registered |

## Verification
An output tick is due on the clock edge right after the selected source tick that completes a period. A new configuration value is due on `rd_data` at the edge that takes the write. The bench drives inputs on the falling edge and updates a behavioural counting model on the rising edge. It compares both outputs with that model at the next falling edge, exactly one register stage after the stimulus. Sweeps over every source and divide code compare total output ticks against floor-divided input tick counts, after two idle cycles that let the last tick drain.

// File: rtl/tick_sel_pkg.sv
package tick_sel_pkg;
    localparam int CFG_W    = 32;
    localparam int SEL_W    = 2;
    localparam int SEL_LSB  = 16;
    localparam int PRE_W    = 5;
    localparam int PRE_LSB  = 8;
    localparam int POST_W   = 2;
    localparam int POST_LSB = 4;
    localparam int NUM_SRC  = 1 << SEL_W;
    localparam int PRESCALED_SRC = NUM_SRC - 1;

    localparam logic [CFG_W-1:0] SEL_MASK   = CFG_W'(((1 << SEL_W) - 1) << SEL_LSB);
    localparam logic [CFG_W-1:0] PRE_MASK   = CFG_W'(((1 << PRE_W) - 1) << PRE_LSB);
    localparam logic [CFG_W-1:0] POST_MASK  = CFG_W'(((1 << POST_W) - 1) << POST_LSB);
    localparam logic [CFG_W-1:0] FIELD_MASK = SEL_MASK | PRE_MASK | POST_MASK;

    typedef enum logic {
        PATH_DIRECT    = 1'b0,
        PATH_PRESCALED = 1'b1
    } path_e;
endpackage

// File: rtl/tick_cfg_reg.sv
module tick_cfg_reg
    import tick_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [CFG_W-1:0] wr_mask,
    output logic [CFG_W-1:0] cfg_q,
    output logic [CFG_W-1:0] cfg_nxt,
    output logic             field_chg
);
    always_comb begin
        cfg_nxt = cfg_q;
        if (wr_en) begin
            cfg_nxt = (cfg_q & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    // Only the three decoded fields count as a reconfiguration.
    assign field_chg = |((cfg_nxt ^ cfg_q) & FIELD_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_nxt;
        end
    end
endmodule

// File: rtl/tick_div_stage.sv
module tick_div_stage #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_tick,
    input  logic [CODE_W-1:0] code,
    output logic              out_tick
);
    logic [CODE_W-1:0] cnt_q;
    logic              wrap;

    assign wrap     = (cnt_q == code);
    assign out_tick = in_tick && wrap && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (in_tick) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tick_rate_sel.sv
module tick_rate_sel
    import tick_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               wr_en,
    input  logic [CFG_W-1:0]   wr_data,
    input  logic [CFG_W-1:0]   wr_mask,
    output logic [CFG_W-1:0]   rd_data,
    output logic               tick_out
);
    logic [CFG_W-1:0]  cfg_q;
    logic [CFG_W-1:0]  cfg_nxt;
    logic              field_chg;
    logic [SEL_W-1:0]  sel;
    logic [SEL_W-1:0]  sel_nxt;
    logic [PRE_W-1:0]  pre_code;
    logic [POST_W-1:0] post_code;
    logic              picked;
    logic              pre_in;
    logic              pre_out;
    logic              post_in;
    logic              post_out;
    logic              tick_q;
    path_e             path_q;
    path_e             path_d;

    tick_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask),
        .cfg_q     (cfg_q),
        .cfg_nxt   (cfg_nxt),
        .field_chg (field_chg)
    );

    assign sel       = cfg_q[SEL_LSB +: SEL_W];
    assign sel_nxt   = cfg_nxt[SEL_LSB +: SEL_W];
    assign pre_code  = cfg_q[PRE_LSB +: PRE_W];
    assign post_code = cfg_q[POST_LSB +: POST_W];

    // Path state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            path_q <= PATH_DIRECT;
        end else begin
            path_q <= path_d;
        end
    end

    // Path transitions, taken only on a committed field change
    always_comb begin
        path_d = path_q;
        unique case (path_q)
            PATH_DIRECT: begin
                if (field_chg && (sel_nxt == SEL_W'(PRESCALED_SRC))) begin
                    path_d = PATH_PRESCALED;
                end
            end
            PATH_PRESCALED: begin
                if (field_chg && (sel_nxt != SEL_W'(PRESCALED_SRC))) begin
                    path_d = PATH_DIRECT;
                end
            end
            default: path_d = PATH_DIRECT;
        endcase
    end

    // Path-dependent routing of the picked tick
    assign picked = src_tick[sel];

    always_comb begin
        pre_in  = 1'b0;
        post_in = 1'b0;
        unique case (path_q)
            PATH_DIRECT: begin
                post_in = picked;
            end
            PATH_PRESCALED: begin
                pre_in  = picked;
                post_in = pre_out;
            end
            default: post_in = 1'b0;
        endcase
    end

    tick_div_stage #(.CODE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (field_chg),
        .in_tick  (pre_in),
        .code     (pre_code),
        .out_tick (pre_out)
    );

    tick_div_stage #(.CODE_W(POST_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (field_chg),
        .in_tick  (post_in),
        .code     (post_code),
        .out_tick (post_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= post_out;
        end
    end

    assign tick_out = tick_q;
    assign rd_data  = cfg_q;
endmodule

// File: rtl/tick_rate_sel_chk.sv
module tick_rate_sel_chk
    import tick_sel_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_tick,
    input logic               wr_en,
    input logic [CFG_W-1:0]   wr_mask,
    input logic [CFG_W-1:0]   rd_data,
    input logic               tick_out
);
    logic                            warm;
    logic [SEL_W-1:0]                c_sel;
    logic [SEL_W+PRE_W+POST_W-1:0]   c_fields;
    logic                            ratio_gt1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    assign c_sel     = rd_data[SEL_LSB +: SEL_W];
    assign c_fields  = {rd_data[SEL_LSB +: SEL_W], rd_data[PRE_LSB +: PRE_W], rd_data[POST_LSB +: POST_W]};
    assign ratio_gt1 = (rd_data[POST_LSB +: POST_W] != '0) ||
                       ((c_sel == SEL_W'(PRESCALED_SRC)) && (rd_data[PRE_LSB +: PRE_W] != '0));

    AST_OUT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        tick_out |-> $past(src_tick[c_sel])); // R2

    AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        ((c_sel != SEL_W'(PRESCALED_SRC)) && (rd_data[POST_LSB +: POST_W] == '0) &&
         $stable(c_fields) && $past(src_tick[c_sel])) |-> tick_out); // R9

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        (ratio_gt1 && tick_out) |=> !tick_out); // R3

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        !wr_en |=> $stable(rd_data)); // R6

    AST_MASKED_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        wr_en |=> (((rd_data ^ $past(rd_data)) & ~$past(wr_mask)) == '0)); // R6

    AST_FIELD_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        !$stable(c_fields) |-> !tick_out); // R8
endmodule

bind tick_rate_sel tick_rate_sel_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .wr_en    (wr_en),
    .wr_mask  (wr_mask),
    .rd_data  (rd_data),
    .tick_out (tick_out)
);

// File: tb/sim_tick_rate_sel.sv
module sim_tick_rate_sel;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [31:0] FM = 32'h0003_1F30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] wr_mask = '0;
    logic [31:0] rd_data;
    logic        tick_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int out_cnt = 0;

    // behavioural model state
    logic [31:0] m_reg = '0;
    logic [31:0] m_nxt;
    int          m_pre_seen = 0;
    int          m_post_seen = 0;
    logic        m_tick = 1'b0;
    logic        m_t;

    tick_rate_sel u0 (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_data(rd_data), .tick_out(tick_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg = '0; m_pre_seen = 0; m_post_seen = 0; m_tick = 1'b0;
        end else begin
            m_nxt = wr_en ? ((m_reg & ~wr_mask) | (wr_data & wr_mask)) : m_reg;
            m_t = src_tick[m_reg[17:16]];
            if (((m_nxt ^ m_reg) & FM) != 0) begin
                m_pre_seen = 0; m_post_seen = 0; m_t = 1'b0;
            end else begin
                if (m_reg[17:16] == 2'd3 && m_t) begin
                    m_pre_seen++;
                    if (m_pre_seen == int'(m_reg[12:8]) + 1) m_pre_seen = 0;
                    else m_t = 1'b0;
                end
                if (m_t) begin
                    m_post_seen++;
                    if (m_post_seen == int'(m_reg[5:4]) + 1) m_post_seen = 0;
                    else m_t = 1'b0;
                end
            end
            m_tick = m_t;
            m_reg  = m_nxt;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // compare against the model, then drive the next inputs
    task automatic step(input logic [3:0] s, input logic we, input logic [31:0] d, input logic [31:0] m);
        @(negedge clk);
        if (m_reg[17:16] == 2'd3)      check("R5 tick", {31'b0, tick_out}, {31'b0, m_tick});
        else if (m_reg[5:4] == 2'd0)   check("R9 tick", {31'b0, tick_out}, {31'b0, m_tick});
        else                           check("R3 tick", {31'b0, tick_out}, {31'b0, m_tick});
        check("R6 readback", rd_data, m_reg);
        if (tick_out === 1'b1) out_cnt++;
        src_tick = s; wr_en = we; wr_data = d; wr_mask = m;
    endtask

    task automatic after_edge();
        @(posedge clk); #1;
    endtask

    task automatic run_combo(input int sel, input int pre, input int post);
        logic [31:0] cfg;
        int in_cnt, ncyc, ratio;
        cfg = ($urandom & ~FM) | (32'(sel) << 16) | (32'(pre) << 8) | (32'(post) << 4);
        step(4'b0, 1'b1, cfg, 32'hFFFF_FFFF);
        in_cnt = 0; out_cnt = 0;
        ncyc = (sel == 3) ? 600 : 150;
        for (int i = 0; i < ncyc; i++) begin
            logic [3:0] s;
            s = 4'($urandom);
            if (s[sel]) in_cnt++;
            step(s, 1'b0, '0, '0);
        end
        step(4'b0, 1'b0, '0, '0);
        step(4'b0, 1'b0, '0, '0);
        ratio = (sel == 3) ? (pre + 1) * (post + 1) : (post + 1);
        if (sel == 3)      check("R2 R5 count", 32'(out_cnt), 32'(in_cnt / ratio));
        else if (pre != 0) check("R2 R4 count", 32'(out_cnt), 32'(in_cnt / ratio));
        else               check("R2 R3 count", 32'(out_cnt), 32'(in_cnt / ratio));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset word", rd_data, 32'h0);
        check("R1 reset tick", {31'b0, tick_out}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        step(4'b0001, 1'b0, '0, '0);
        after_edge();
        check("R1 default pass-through", {31'b0, tick_out}, 32'h1);

        // sweep every source and output-divide code
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 4; c++) begin
                run_combo(s, 0, c);
                run_combo(s, 4, c);
                run_combo(s, 31, c);
            end

        // R6 masked write of one field
        step(4'b0, 1'b1, 32'h0003_0520, 32'hFFFF_FFFF);
        step(4'b0, 1'b1, 32'h0000_0000, 32'h0000_0030);
        after_edge();
        check("R6 masked field write", rd_data, 32'h0003_0500);

        // R7 free bits do not disturb counters
        step(4'b0, 1'b1, 32'h0000_0010, 32'hFFFF_FFFF);
        step(4'b0001, 1'b0, '0, '0);
        step(4'b0, 1'b1, 32'h8000_0000, 32'h8000_0000);
        step(4'b0001, 1'b0, '0, '0);
        after_edge();
        check("R7 counter kept across free-bit write", {31'b0, tick_out}, 32'h1);
        step(4'b0, 1'b0, '0, '0);
        after_edge();
        check("R7 free bit readback", {31'b0, rd_data[31]}, 32'h1);

        // R8 field change restarts the period and drops its tick
        step(4'b0, 1'b1, 32'h0000_0010, 32'hFFFF_FFFF);
        step(4'b0001, 1'b0, '0, '0);
        step(4'b0001, 1'b1, 32'h0000_0700, 32'h0000_1F00);
        after_edge();
        check("R8 write-cycle tick dropped", {31'b0, tick_out}, 32'h0);
        step(4'b0001, 1'b0, '0, '0);
        after_edge();
        check("R8 first tick after restart", {31'b0, tick_out}, 32'h0);
        step(4'b0001, 1'b0, '0, '0);
        after_edge();
        check("R8 full new period", {31'b0, tick_out}, 32'h1);

        // R9 direct pass, one cycle wide
        step(4'b0, 1'b1, 32'h0002_0000, 32'hFFFF_FFFF);
        step(4'b0100, 1'b0, '0, '0);
        after_edge();
        check("R9 tick one cycle later", {31'b0, tick_out}, 32'h1);
        step(4'b0000, 1'b0, '0, '0);
        after_edge();
        check("R9 single-cycle width", {31'b0, tick_out}, 32'h0);

        step(4'b0, 1'b0, '0, '0);
        done = 1;
        summary();
        $finish;
    end
endmodule